// File: doc/BRIEF.md
# Integer Status Flag Unit

This block derives the integer status bits that follow a fixed-point ALU operation. An execution pipe presents the operands it used, an optional immediate, the produced result and a handful of control qualifiers. The unit then updates its held copies of the carry (CA), 32-bit carry (CA32), overflow (OV), 32-bit overflow (OV32) and summary overflow (SO) bits, and a 4-bit condition field for record forms. The arithmetic is done elsewhere. This block only examines the operands and the result.

All state is held in registers. An update takes effect on the clock edge where `upd` is high, and the new values are visible from the next cycle. The operand width is the parameter `XLEN`, and the half-word boundary used by the 32-bit flags sits at `XLEN/2`. At the default of 64 this gives the usual 64/32 split.

Top module: `flag_unit`

## Requirements
- R1: After reset every flag output and `crf_q` read 0. All outputs change only on a clock edge where `upd` is high, and they hold their values in every other cycle.
- R2: The first operand is bitwise inverted before any flag is evaluated when `inv_a` is high. The second operand is `src_b` when `src_b_ok` is high, and otherwise `imm` when `imm_ok` is high. When both are valid, `imm` also takes part as a third operand in the carry comparisons.
- R3: With `ca_en` high, CA becomes 1 exactly when some present operand is greater than `res`, both taken as unsigned XLEN-bit values.
- R4: With `ca_en` and `is_add` high, CA32 becomes `res[XLEN/2] ^ a[XLEN/2] ^ b[XLEN/2]`, where b is 0 when there is no second operand. With `is_add` low, CA32 becomes 1 exactly when the low XLEN/2 bits of some present operand are greater than the low XLEN/2 bits of `res`, both taken as unsigned.
- R5: `ca_done` high leaves CA unchanged and `ca32_done` high leaves CA32 unchanged, even when `ca_en` is high.
- R6: With `ov_en` high, `divov_ok` low and a second operand present, OV is 1 exactly when the first two operands share a sign bit (bit XLEN-1) and the sign of `res` differs from it. OV32 applies the same rule using bit XLEN/2-1.
- R7: With `ov_en` and `divov_ok` high, both OV and OV32 take the value of `divov`. With `ov_en` high, no second operand and `divov_ok` low, OV, OV32 and SO are left unchanged.
- R8: Whenever OV is updated, SO becomes the OR of its previous value and the new OV. SO is never cleared except by reset.
- R9: With `rec_en` high, `crf_q` becomes {negative, positive, zero, SO} in bits 3 down to 0. The first three are taken from `res` read as a signed number, and SO is the value after any overflow update on the same edge.
- R10: A flag group changes only when its enable is high. `ca_en` gates CA and CA32, `ov_en` gates OV, OV32 and SO, and `rec_en` gates `crf_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Apply a flag update on this edge |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand |
| src_b_ok | input | 1 | `src_b` is present |
| imm | input | XLEN | Immediate operand |
| imm_ok | input | 1 | `imm` is present |
| res | input | XLEN | Operation result |
| inv_a | input | 1 | Invert first operand before evaluation |
| is_add | input | 1 | Operation is an add (selects CA32 rule) |
| ca_en | input | 1 | Update CA/CA32 |
| ov_en | input | 1 | Update OV/OV32/SO |
| rec_en | input | 1 | Update condition field |
| divov_ok | input | 1 | `divov` supplies the overflow value |
| divov | input | 1 | Externally computed divide overflow |
| ca_done | input | 1 | Suppress CA update |
| ca32_done | input | 1 | Suppress CA32 update |
| ca_q | output | 1 | Carry |
| ca32_q | output | 1 | 32-bit carry |
| ov_q | output | 1 | Overflow |
| ov32_q | output | 1 | 32-bit overflow |
| so_q | output | 1 | Summary overflow |
| crf_q | output | 4 | Condition field {neg,pos,zero,so} |

## Verification
Every result is due exactly one clock edge after the cycle in which `upd` is sampled high. No output has more than one register between the inputs and the pins. The bench drives inputs on the falling edge, lets one rising edge pass, and samples all outputs just after that edge, before the next stimulus goes out. For the hold requirements, the bench applies a stimulus with the relevant enable low, or with the suppression bit set, and compares the outputs against the model state carried over from the previous step.

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            src_b_ok,
  input  logic [XLEN-1:0] imm,
  input  logic            imm_ok,
  input  logic [XLEN-1:0] res,
  input  logic            inv_a,
  input  logic            is_add,
  input  logic            ca_en,
  input  logic            ov_en,
  input  logic            rec_en,
  input  logic            divov_ok,
  input  logic            divov,
  input  logic            ca_done,
  input  logic            ca32_done,
  output logic            ca_q,
  output logic            ca32_q,
  output logic            ov_q,
  output logic            ov32_q,
  output logic            so_q,
  output logic [3:0]      crf_q
);
  localparam int H = XLEN / 2;

  logic [XLEN-1:0] a_eff, op2;
  logic            op2_ok, op3_ok;
  logic            ca_new, ca32_new, ca32_cmp, ov_sgn, ov32_sgn;
  logic            ov_upd, ov_new, ov32_new, so_next;
  logic            r_neg, r_zero, r_pos;

  assign a_eff  = inv_a ? ~src_a : src_a;
  assign op2    = src_b_ok ? src_b : imm;
  assign op2_ok = src_b_ok | imm_ok;
  assign op3_ok = src_b_ok & imm_ok;

  assign ca_new = (a_eff > res) | (op2_ok & (op2 > res)) | (op3_ok & (imm > res));

  assign ca32_cmp = (a_eff[H-1:0] > res[H-1:0])
                  | (op2_ok & (op2[H-1:0] > res[H-1:0]))
                  | (op3_ok & (imm[H-1:0] > res[H-1:0]));
  assign ca32_new = is_add ? (res[H] ^ a_eff[H] ^ (op2_ok & op2[H])) : ca32_cmp;

  assign ov_sgn   = (a_eff[XLEN-1] == op2[XLEN-1]) & (res[XLEN-1] != a_eff[XLEN-1]);
  assign ov32_sgn = (a_eff[H-1] == op2[H-1]) & (res[H-1] != a_eff[H-1]);

  assign ov_upd   = ov_en & (divov_ok | op2_ok);
  assign ov_new   = divov_ok ? divov : ov_sgn;
  assign ov32_new = divov_ok ? divov : ov32_sgn;
  assign so_next  = so_q | (ov_upd & ov_new);

  assign r_neg  = res[XLEN-1];
  assign r_zero = (res == '0);
  assign r_pos  = ~r_neg & ~r_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_q   <= 1'b0;
      ca32_q <= 1'b0;
      ov_q   <= 1'b0;
      ov32_q <= 1'b0;
      so_q   <= 1'b0;
      crf_q  <= 4'b0;
    end else if (upd) begin
      if (ca_en && !ca_done)   ca_q   <= ca_new;
      if (ca_en && !ca32_done) ca32_q <= ca32_new;
      if (ov_upd) begin
        ov_q   <= ov_new;
        ov32_q <= ov32_new;
        so_q   <= so_next;
      end
      if (rec_en) crf_q <= {r_neg, r_pos, r_zero, so_next};
    end
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({ca_q, ca32_q, ov_q, ov32_q, so_q, crf_q}));

  p_ca_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && ca_done |=> $stable(ca_q));

  p_ca32_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && ca32_done |=> $stable(ca32_q));

  p_divov_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd && ov_en && divov_ok |=> (ov_q == $past(divov)) && (ov32_q == $past(divov)));

  p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd && ov_en && !divov_ok && !src_b_ok && !imm_ok |=> $stable({ov_q, ov32_q, so_q}));

  p_so_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    so_q |=> so_q);

  p_cr_so_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd && rec_en |=> (crf_q[0] == so_q) && $onehot(crf_q[3:1]));

  p_ov_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !ov_en |=> $stable({ov_q, ov32_q, so_q}));

  p_ca_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !ca_en |=> $stable({ca_q, ca32_q}));
endmodule

// File: tb/flag_unit_tb.sv
module flag_unit_tb_top;
  localparam int W = 8;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [W-1:0] src_a = '0, src_b = '0, imm = '0, res = '0;
  logic src_b_ok = 0, imm_ok = 0, inv_a = 0, is_add = 0;
  logic ca_en = 0, ov_en = 0, rec_en = 0, divov_ok = 0, divov = 0;
  logic ca_done = 0, ca32_done = 0;
  logic ca_q, ca32_q, ov_q, ov32_q, so_q;
  logic [3:0] crf_q;

  int checks = 0, fails = 0;
  logic e_ca = 0, e_ca32 = 0, e_ov = 0, e_ov32 = 0, e_so = 0;
  logic [3:0] e_cr = '0;

  always #2 clk = ~clk;

  flag_unit #(.XLEN(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd(upd), .src_a(src_a), .src_b(src_b),
    .src_b_ok(src_b_ok), .imm(imm), .imm_ok(imm_ok), .res(res), .inv_a(inv_a),
    .is_add(is_add), .ca_en(ca_en), .ov_en(ov_en), .rec_en(rec_en),
    .divov_ok(divov_ok), .divov(divov), .ca_done(ca_done), .ca32_done(ca32_done),
    .ca_q(ca_q), .ca32_q(ca32_q), .ov_q(ov_q), .ov32_q(ov32_q), .so_q(so_q),
    .crf_q(crf_q));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model();
    int a, ops[3], n, lo;
    logic sa, sb, sr, sa32, sb32, sr32, nv, nv32, cy, cy32;
    a = inv_a ? (~src_a & ((1 << W) - 1)) : src_a;
    n = 0;
    ops[n++] = a;
    if (src_b_ok) ops[n++] = src_b;
    if (imm_ok) ops[n++] = imm;
    lo = (1 << H) - 1;
    cy = 0; cy32 = 0;
    for (int i = 0; i < n; i++) begin
      if (ops[i] > res) cy = 1;
      if ((ops[i] & lo) > (res & lo)) cy32 = 1;
    end
    if (is_add) cy32 = ((res >> H) ^ (a >> H) ^ ((n > 1 ? ops[1] : 0) >> H)) & 1;
    if (upd && ca_en && !ca_done) e_ca = cy;
    if (upd && ca_en && !ca32_done) e_ca32 = cy32;
    if (upd && ov_en && (divov_ok || n > 1)) begin
      if (divov_ok) begin
        nv = divov; nv32 = divov;
      end else begin
        sa = a[W-1]; sb = ops[1] >= (1 << (W-1)); sr = res[W-1];
        nv = (sa == sb) && (sr != sa);
        sa32 = a[H-1]; sb32 = ((ops[1] >> (H-1)) & 1) != 0; sr32 = res[H-1];
        nv32 = (sa32 == sb32) && (sr32 != sa32);
      end
      e_ov = nv; e_ov32 = nv32; e_so = e_so | nv;
    end
    if (upd && rec_en)
      e_cr = {$signed(res) < 0, $signed(res) > 0, res == 0, e_so};
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    model();
    @(posedge clk);
    #1;
    chk({tag, " R3 ca"}, ca_q, e_ca);
    chk({tag, " R4 ca32"}, ca32_q, e_ca32);
    chk({tag, " R6 ov"}, ov_q, e_ov);
    chk({tag, " R6 ov32"}, ov32_q, e_ov32);
    chk({tag, " R8 so"}, so_q, e_so);
    chk({tag, " R9 crf"}, crf_q, e_cr);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {ca_q, ca32_q, ov_q, ov32_q, so_q, crf_q}, 0);
    @(negedge clk); rst_n = 1;

    upd = 1; ca_en = 1; ov_en = 1; rec_en = 1; src_b_ok = 1;
    src_a = 8'h0F; src_b = 8'h01; res = 8'h10; is_add = 1;
    step("R2 plain");
    inv_a = 1; is_add = 0;
    step("R2 invert");
    inv_a = 0; src_b_ok = 0; imm_ok = 1; imm = 8'h7F; res = 8'h80;
    step("R2 imm as second");
    src_b_ok = 1; src_b = 8'h01; imm = 8'hF0; res = 8'h20;
    step("R3 imm third");
    ca_done = 1; ca32_done = 1; src_a = 8'hFF; res = 8'h00;
    step("R5 both suppressed");
    ca_done = 0;
    step("R5 ca32 suppressed");
    ca_done = 0; ca32_done = 0;
    divov_ok = 1; divov = 1;
    step("R7 divov set");
    divov = 0;
    step("R7 divov clear keeps so");
    divov_ok = 0; src_b_ok = 0; imm_ok = 0; src_a = 8'h7F; res = 8'h80;
    step("R7 single operand hold");
    ca_en = 0; ov_en = 0; rec_en = 0; src_b_ok = 1; src_a = 8'hAA; res = 8'h00;
    step("R10 all gated");
    upd = 0; ca_en = 1; ov_en = 1; rec_en = 1;
    step("R1 idle");

    @(negedge clk); rst_n = 0; e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0; e_cr = 0;
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 6000; k++) begin
      {upd, src_b_ok, imm_ok, inv_a, is_add, ca_en, ov_en, rec_en} = 8'($urandom);
      if ((k % 4) != 0) upd = 1;
      divov_ok = ($urandom % 5) == 0; divov = 1'($urandom);
      ca_done = ($urandom % 4) == 0; ca32_done = ($urandom % 4) == 0;
      src_a = 8'($urandom); src_b = 8'($urandom); imm = 8'($urandom); res = 8'($urandom);
      if ((k % 7) == 0) res = 8'h00;
      if ((k % 50) == 49) begin
        @(negedge clk); rst_n = 0; e_ca = 0; e_ca32 = 0; e_ov = 0; e_ov32 = 0; e_so = 0; e_cr = 0;
        @(negedge clk); rst_n = 1;
      end
      step("R10 sweep");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule